// File: doc/BRIEF.md
# Pixel Detector Data Word Parser

The parser sits after the byte decoder of one pixel detector data lane. It accepts one decoded byte per cycle, qualified by a valid flag. It works out from the leading bits of each word how many bytes that word spans, which is one, two or three. When the last byte arrives it emits one typed record with the extracted fields. Cycles with the valid flag low are skipped, so a word can be spread across gaps.

Alongside the records, the parser tracks whether a chip frame is open and whether a region has been announced since the frame began. It raises a one-cycle protocol error pulse when a word arrives in the wrong context or has an illegal encoding. It also keeps a busy level for a downstream control block. Each record carries the chip id and region id currently in force, so that hits can be placed without extra state downstream.

Top module: `pixel_word_parser`

## Requirements
- R1: Single-byte words produce a record whose `recValid` pulse is high in the cycle after the byte is accepted. Recognised bytes: 0xFF idle, 0xF1 busy on, 0xF0 busy off, 1011_ffff trailer, 110r_rrrr region header. `recKind` codes: 0 idle, 1 busy on, 2 busy off, 3 chip header, 4 trailer, 5 empty frame, 6 region header, 7 short hit, 8 long hit.
- R2: Multi-byte words are assembled from the lead byte onward: chip header (1010_cccc) takes 2 bytes, empty frame (1110_cccc) takes 2, short hit (01xx_xxxx) takes 2 and long hit (00xx_xxxx) takes 3. Cycles without a valid byte between the bytes of a word are skipped. Bytes after the lead byte are never classified. The record appears in the cycle after the final byte.
- R3: Field extraction:
  - Chip header and empty frame: bunch field = byte 2.
  - Trailer: flags = lead[3:0].
  - Short and long hits: encoder = lead[5:2], address = {lead[1:0], byte 2}.
  - Long hit: hit map = byte 3 [6:0].
  - Fields that a kind does not define read zero in its record.
- R4: `recChipId` holds the lead[3:0] of the latest chip header or empty frame. `recRegionId` holds the [4:0] of the latest region header. Both already reflect the word that just completed, both are 0 after reset, and both stay unchanged while no record is emitted.
- R5: A chip header opens a frame, while a trailer or an empty frame closes it. A chip header or empty frame inside an open frame pulses `protoErr`, as does a trailer, region header or hit word outside a frame. The record is still emitted and the frame state still updates.
- R6: `busyLevel` is set by the busy-on record and cleared by the busy-off record. It changes at no other time.
- R7: A hit word that arrives after a chip header but before any region header of that frame pulses `protoErr`.
- R8: `protoErr` also pulses in two more cases. A long hit whose third byte has bit 7 set gives an error with its record. A lead byte 100x_xxxx, or 1111_xxxx other than 0xFF, 0xF1 and 0xF0, gives an error without any record, and the next byte is treated as a lead byte.
- R9: Reset clears `recValid`, `protoErr`, `busyLevel`, the frame state and both ids, and drops any partly assembled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | Byte on `byteIn` is valid this cycle |
| byteIn | input | 8 | Decoded data byte |
| recValid | output | 1 | One-cycle pulse: a record is present |
| recKind | output | 4 | Record type code (R1) |
| recChipId | output | 4 | Current chip id |
| recRegionId | output | 5 | Current region id |
| recBunch | output | 8 | Bunch counter field |
| recFlags | output | 4 | Trailer readout flags |
| recEncoder | output | 4 | Hit encoder id |
| recAddr | output | 10 | Hit address |
| recHitMap | output | 7 | Long-hit neighbour map |
| protoErr | output | 1 | One-cycle protocol error pulse |
| busyLevel | output | 1 | Busy status level |

## Verification
Every result of the parser is due exactly one clock after the byte that triggers it has been accepted. This holds for the record pulse and its fields, the error pulse, the busy level and both context ids. A multi-byte word produces nothing until its final byte, however many empty cycles sit in between. The bench drives one byte or gap per cycle on the falling edge and advances its reference model by the same step. On the next falling edge it compares the model with the outputs, so each expectation is checked in the cycle it becomes due. Pulses are also confirmed to be low in every other cycle.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

  localparam int BYTE_W   = 8;
  localparam int CHIP_W   = 4;
  localparam int REGION_W = 5;
  localparam int ENC_W    = 4;
  localparam int ADDR_W   = 10;
  localparam int HIT_W    = 7;
  localparam int FLAG_W   = 4;
  localparam int KIND_W   = 4;
  localparam int ADDR_HI  = ADDR_W - BYTE_W;
  localparam int LEAD_W   = ENC_W + ADDR_HI;

  typedef enum logic [KIND_W-1:0] {
    KIND_IDLE     = 4'd0,
    KIND_BUSY_ON  = 4'd1,
    KIND_BUSY_OFF = 4'd2,
    KIND_CHIP_HDR = 4'd3,
    KIND_CHIP_TRL = 4'd4,
    KIND_EMPTY    = 4'd5,
    KIND_REGION   = 4'd6,
    KIND_SHORT    = 4'd7,
    KIND_LONG     = 4'd8
  } wordKind_t;

  typedef struct packed {
    logic      loadFirst;
    logic      loadSecond;
    logic      finish;
    wordKind_t kind;
  } pwpStrobe_t;

  function automatic wordKind_t classifyLead(input logic [BYTE_W-1:0] b);
    wordKind_t k;
    if (b[7:6] == 2'b00)       k = KIND_LONG;
    else if (b[7:6] == 2'b01)  k = KIND_SHORT;
    else if (b[7:5] == 3'b110) k = KIND_REGION;
    else if (b[7:4] == 4'hA)   k = KIND_CHIP_HDR;
    else if (b[7:4] == 4'hB)   k = KIND_CHIP_TRL;
    else if (b[7:4] == 4'hE)   k = KIND_EMPTY;
    else if (b == 8'hF1)       k = KIND_BUSY_ON;
    else if (b == 8'hF0)       k = KIND_BUSY_OFF;
    else                       k = KIND_IDLE;
    return k;
  endfunction

  function automatic logic leadKnown(input logic [BYTE_W-1:0] b);
    logic ok;
    ok = 1'b1;
    if (b[7:5] == 3'b100) ok = 1'b0;
    if (b[7:4] == 4'hF && b != 8'hFF && b != 8'hF1 && b != 8'hF0) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [1:0] wordBytes(input wordKind_t k);
    logic [1:0] n;
    case (k)
      KIND_CHIP_HDR, KIND_EMPTY, KIND_SHORT: n = 2'd2;
      KIND_LONG:                             n = 2'd3;
      default:                               n = 2'd1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pwp_ctrl.sv
module pwp_ctrl
  import pwp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  output pwpStrobe_t        strobe,
  output logic              protoErr,
  output logic              busyLevel
);

  logic [1:0] phase;
  wordKind_t  pendKind;
  wordKind_t  leadKind;
  wordKind_t  curKind;
  logic       known;
  logic       lastByte;
  logic       violation;
  logic       inFrame;
  logic       needRegion;

  always_comb begin
    leadKind = classifyLead(byteIn);
    known    = leadKnown(byteIn);
    curKind  = (phase == 2'd0) ? leadKind : pendKind;
    if (phase == 2'd0)      lastByte = (wordBytes(leadKind) == 2'd1);
    else if (phase == 2'd1) lastByte = (wordBytes(pendKind) == 2'd2);
    else                    lastByte = 1'b1;
  end

  always_comb begin
    strobe.kind       = curKind;
    strobe.loadFirst  = byteValid && (phase == 2'd0) && known && !lastByte;
    strobe.loadSecond = byteValid && (phase == 2'd1) && !lastByte;
    strobe.finish     = byteValid && (phase != 2'd0 || known) && lastByte;
  end

  always_comb begin
    case (curKind)
      KIND_CHIP_HDR, KIND_EMPTY:   violation = inFrame;
      KIND_CHIP_TRL, KIND_REGION:  violation = !inFrame;
      KIND_SHORT:                  violation = !inFrame || needRegion;
      KIND_LONG:                   violation = !inFrame || needRegion || byteIn[7];
      default:                     violation = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= 2'd0;
      pendKind   <= KIND_IDLE;
      inFrame    <= 1'b0;
      needRegion <= 1'b0;
      busyLevel  <= 1'b0;
      protoErr   <= 1'b0;
    end else begin
      protoErr <= (byteValid && phase == 2'd0 && !known) || (strobe.finish && violation);
      if (strobe.finish)          phase <= 2'd0;
      else if (strobe.loadFirst)  phase <= 2'd1;
      else if (strobe.loadSecond) phase <= 2'd2;
      if (strobe.loadFirst) pendKind <= leadKind;
      if (strobe.finish) begin
        case (curKind)
          KIND_CHIP_HDR: begin inFrame <= 1'b1; needRegion <= 1'b1; end
          KIND_EMPTY, KIND_CHIP_TRL: begin inFrame <= 1'b0; needRegion <= 1'b0; end
          KIND_REGION:   needRegion <= 1'b0;
          KIND_BUSY_ON:  busyLevel <= 1'b1;
          KIND_BUSY_OFF: busyLevel <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  AST_ERR_ON_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(byteValid)); // R5
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd2) |-> (pendKind == KIND_LONG)); // R2

endmodule

// File: rtl/pwp_datapath.sv
module pwp_datapath
  import pwp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [BYTE_W-1:0]   byteIn,
  input  pwpStrobe_t          strobe,
  output logic                recValid,
  output logic [KIND_W-1:0]   recKind,
  output logic [CHIP_W-1:0]   recChipId,
  output logic [REGION_W-1:0] recRegionId,
  output logic [BYTE_W-1:0]   recBunch,
  output logic [FLAG_W-1:0]   recFlags,
  output logic [ENC_W-1:0]    recEncoder,
  output logic [ADDR_W-1:0]   recAddr,
  output logic [HIT_W-1:0]    recHitMap
);

  logic [LEAD_W-1:0] leadLow;
  logic [BYTE_W-1:0] midByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leadLow <= '0;
      midByte <= '0;
    end else begin
      if (strobe.loadFirst)  leadLow <= byteIn[LEAD_W-1:0];
      if (strobe.loadSecond) midByte <= byteIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recValid    <= 1'b0;
      recKind     <= '0;
      recChipId   <= '0;
      recRegionId <= '0;
      recBunch    <= '0;
      recFlags    <= '0;
      recEncoder  <= '0;
      recAddr     <= '0;
      recHitMap   <= '0;
    end else begin
      recValid <= strobe.finish;
      if (strobe.finish) begin
        recKind    <= strobe.kind;
        recBunch   <= '0;
        recFlags   <= '0;
        recEncoder <= '0;
        recAddr    <= '0;
        recHitMap  <= '0;
        case (strobe.kind)
          KIND_CHIP_HDR, KIND_EMPTY: begin
            recChipId <= leadLow[CHIP_W-1:0];
            recBunch  <= byteIn;
          end
          KIND_CHIP_TRL: recFlags    <= byteIn[FLAG_W-1:0];
          KIND_REGION:   recRegionId <= byteIn[REGION_W-1:0];
          KIND_SHORT: begin
            recEncoder <= leadLow[LEAD_W-1:ADDR_HI];
            recAddr    <= {leadLow[ADDR_HI-1:0], byteIn};
          end
          KIND_LONG: begin
            recEncoder <= leadLow[LEAD_W-1:ADDR_HI];
            recAddr    <= {leadLow[ADDR_HI-1:0], midByte};
            recHitMap  <= byteIn[HIT_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !recValid |-> ($stable(recChipId) && $stable(recRegionId))); // R4

endmodule

// File: rtl/pixel_word_parser.sv
module pixel_word_parser
  import pwp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                byteValid,
  input  logic [BYTE_W-1:0]   byteIn,
  output logic                recValid,
  output logic [KIND_W-1:0]   recKind,
  output logic [CHIP_W-1:0]   recChipId,
  output logic [REGION_W-1:0] recRegionId,
  output logic [BYTE_W-1:0]   recBunch,
  output logic [FLAG_W-1:0]   recFlags,
  output logic [ENC_W-1:0]    recEncoder,
  output logic [ADDR_W-1:0]   recAddr,
  output logic [HIT_W-1:0]    recHitMap,
  output logic                protoErr,
  output logic                busyLevel
);

  pwpStrobe_t strobe;

  pwp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteIn    (byteIn),
    .strobe    (strobe),
    .protoErr  (protoErr),
    .busyLevel (busyLevel)
  );

  pwp_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .byteIn      (byteIn),
    .strobe      (strobe),
    .recValid    (recValid),
    .recKind     (recKind),
    .recChipId   (recChipId),
    .recRegionId (recRegionId),
    .recBunch    (recBunch),
    .recFlags    (recFlags),
    .recEncoder  (recEncoder),
    .recAddr     (recAddr),
    .recHitMap   (recHitMap)
  );

  AST_REC_ON_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> $past(byteValid)); // R1
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyLevel) |-> (recValid && recKind == KIND_BUSY_ON)); // R6
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyLevel) |-> (recValid && recKind == KIND_BUSY_OFF)); // R6
  AST_REGION_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recKind == KIND_REGION) |-> (recRegionId == $past(byteIn[REGION_W-1:0]))); // R3

endmodule

// File: tb/pixel_word_parser_tb.sv
module pixel_word_parser_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic       recValid, protoErr, busyLevel;
  logic [3:0] recKind, recChipId, recFlags, recEncoder;
  logic [4:0] recRegionId;
  logic [7:0] recBunch;
  logic [9:0] recAddr;
  logic [6:0] recHitMap;

  always #2.5 clk = ~clk;

  pixel_word_parser u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .recValid(recValid), .recKind(recKind), .recChipId(recChipId),
    .recRegionId(recRegionId), .recBunch(recBunch), .recFlags(recFlags),
    .recEncoder(recEncoder), .recAddr(recAddr), .recHitMap(recHitMap),
    .protoErr(protoErr), .busyLevel(busyLevel)
  );

  int total = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R9";

  // reference model state
  logic [7:0] pend[$];
  int need;
  bit mFrame, mNeedReg, mBusy;
  int mChip, mRegion;
  bit eValid, eErr;
  int eKind, eBunch, eFlags, eEnc, eAddr, eHit;

  function automatic int kindOf(input logic [7:0] b);
    casez (b)
      8'b00??????: return 8;
      8'b01??????: return 7;
      8'b110?????: return 6;
      8'b1010????: return 3;
      8'b1011????: return 4;
      8'b1110????: return 5;
      8'hFF:       return 0;
      8'hF1:       return 1;
      8'hF0:       return 2;
      default:     return 15;
    endcase
  endfunction

  task automatic modelReset();
    pend.delete();
    need = 0; mFrame = 0; mNeedReg = 0; mBusy = 0; mChip = 0; mRegion = 0;
    eValid = 0; eErr = 0;
  endtask

  task automatic modelFinish();
    int k;
    k = kindOf(pend[0]);
    eValid = 1; eKind = k;
    eBunch = 0; eFlags = 0; eEnc = 0; eAddr = 0; eHit = 0;
    if (k == 3 || k == 5) begin
      if (mFrame) eErr = 1;
      mChip = pend[0] & 15; eBunch = pend[1];
      mFrame = (k == 3); mNeedReg = (k == 3);
    end else if (k == 4) begin
      if (!mFrame) eErr = 1;
      eFlags = pend[0] & 15; mFrame = 0; mNeedReg = 0;
    end else if (k == 6) begin
      if (!mFrame) eErr = 1;
      mRegion = pend[0] & 31; mNeedReg = 0;
    end else if (k == 7 || k == 8) begin
      if (!mFrame || mNeedReg) eErr = 1;
      eEnc = (pend[0] >> 2) & 15;
      eAddr = (pend[0] & 3) * 256 + pend[1];
      if (k == 8) begin
        eHit = pend[2] & 127;
        if (pend[2][7]) eErr = 1;
      end
    end else if (k == 1) mBusy = 1;
    else if (k == 2) mBusy = 0;
    pend.delete();
  endtask

  task automatic modelStep(input bit v, input logic [7:0] b);
    int k;
    eValid = 0; eErr = 0;
    if (!v) return;
    if (pend.size() == 0) begin
      k = kindOf(b);
      if (k == 15) begin eErr = 1; return; end
      need = (k == 8) ? 3 : ((k == 3 || k == 5 || k == 7) ? 2 : 1);
    end
    pend.push_back(b);
    if (pend.size() == need) modelFinish();
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check(recValid == eValid, "recValid", recValid, eValid);
    check(protoErr == eErr, "protoErr", protoErr, eErr);
    check(busyLevel == mBusy, "busyLevel", busyLevel, mBusy);
    check(recChipId == mChip, "recChipId", recChipId, mChip);
    check(recRegionId == mRegion, "recRegionId", recRegionId, mRegion);
    if (eValid) begin
      check(recKind == eKind, "recKind", recKind, eKind);
      check(recBunch == eBunch, "recBunch", recBunch, eBunch);
      check(recFlags == eFlags, "recFlags", recFlags, eFlags);
      check(recEncoder == eEnc, "recEncoder", recEncoder, eEnc);
      check(recAddr == eAddr, "recAddr", recAddr, eAddr);
      check(recHitMap == eHit, "recHitMap", recHitMap, eHit);
    end
  endtask

  task automatic cycle(input bit v, input logic [7:0] b);
    byteValid = v; byteIn = b;
    modelStep(v, b);
    @(negedge clk);
    compareAll();
  endtask

  task automatic sendByte(input logic [7:0] b); cycle(1'b1, b); endtask
  task automatic gap(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 8'h5A);
  endtask

  task automatic doReset();
    rstN = 0; byteValid = 0;
    modelReset();
    @(negedge clk); @(negedge clk);
    curReq = "R9";
    compareAll();
    rstN = 1;
  endtask

  initial begin
    modelReset();
    doReset();
    // R9: frame closed after reset, trailer flags error
    sendByte(8'hB0);

    curReq = "R1";
    sendByte(8'hFF); gap(1);
    curReq = "R6";
    sendByte(8'hF1); sendByte(8'hFF); gap(2); sendByte(8'hF0); gap(1);

    curReq = "R2";
    sendByte(8'hA5); gap(3); sendByte(8'h3C);
    curReq = "R3";
    sendByte(8'hC7);
    sendByte(8'h4E); gap(1); sendByte(8'hAB);
    curReq = "R2";
    sendByte(8'h25); gap(2); sendByte(8'h55); gap(1); sendByte(8'h55);
    // lead-like continuation bytes are not classified
    sendByte(8'h7F); sendByte(8'hFF);
    sendByte(8'h00); sendByte(8'hF1); sendByte(8'h7F);
    curReq = "R4";
    sendByte(8'hDF); sendByte(8'h40); sendByte(8'h01);
    curReq = "R3";
    sendByte(8'hB9);
    sendByte(8'hE2); sendByte(8'h77);

    curReq = "R5";
    sendByte(8'hB3);
    sendByte(8'hC2);
    sendByte(8'h41); sendByte(8'h10);
    sendByte(8'hA1); sendByte(8'h00);
    sendByte(8'hC1);
    sendByte(8'hA2); sendByte(8'h11);
    sendByte(8'hE3); sendByte(8'h22);

    curReq = "R7";
    sendByte(8'hA4); sendByte(8'h99);
    sendByte(8'h45); sendByte(8'h66);
    sendByte(8'hC3);
    sendByte(8'h45); sendByte(8'h66);

    curReq = "R8";
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h85);
    sendByte(8'hF5); sendByte(8'h90); sendByte(8'hB5);
    sendByte(8'hF1); gap(1);

    curReq = "R9";
    sendByte(8'hA6);
    doReset();
    sendByte(8'hFF);
    sendByte(8'hC4);
    gap(2);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule